// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit virtual address into a 36-bit physical address by walking in-memory translation tables. A walk begins with one word read from a context table, picked by a context table pointer and a context number, and then descends through up to three table levels. A page entry may end the walk at the first level (16 MB page), the second (256 KB page) or the third (4 KB page). All table reads, and the single optional write-back of status bits, go through a word-wide memory port with a valid/ready request side and a response strobe.

When the walk ends the block pulses `done` and presents the final entry, the level at which the walk stopped, the physical address, and a fault code that packs the level and the kind of fault. Permission decisions are left to a downstream checker. The request's write, fetch and supervisor flags are returned with the result for that checker's use. When translation is switched off the virtual address is passed straight through, flagged as full-permission, and memory is not touched.

The controller has five states. S_IDLE accepts a request. With translation enabled it moves to S_RD_ISSUE, otherwise to S_FINISH. S_RD_ISSUE holds a read until the memory accepts it, then moves to S_RD_WAIT. S_RD_WAIT waits for the response and then goes to one of three places: back to S_RD_ISSUE when the entry is a table descriptor below the last level; to S_WB_ISSUE when a page entry needs its status bits updated; to S_FINISH for a page entry that needs no update or for any fault. S_WB_ISSUE holds the write until it is accepted and then moves to S_FINISH. S_FINISH raises `done` for one cycle and returns to S_IDLE.

Top module: `ptw_walker`

## Requirements
- R1: The first read of a walk goes to address (ctx_ptr << 4) + (ctx_num << 2).
- R2: Each fetched entry's bits [1:0] give its type (0 invalid, 1 table descriptor, 2 page entry, 3 reserved). A table descriptor at level L (0 = context, 1..2) leads to a read at ({entry[31:2], 6'b0}) + 4 × index. The index is va[31:24] for level 1, va[23:18] for level 2 and va[17:12] for level 3.
- R3: A page entry at level 1, 2 or 3 ends the walk without fault. res_level is that level and res_paddr = {entry[31:8], 12'b0} + offset. The offset is va[23:0], va[17:0] or va[11:0] respectively.
- R4: An invalid entry ends the walk with res_fault[9:8] = level, res_fault[4:2] = 1, all other bits 0. res_pte holds the entry and res_paddr is 0.
- R5: A reserved entry at any level, a page entry in the context table, or a table descriptor at level 3 ends the walk with res_fault[9:8] = level and res_fault[4:2] = 4.
- R6: A page entry whose referenced bit (bit 5) is clear, or which is reached by a write while its modified bit (bit 6) is clear, is written back to the address it was read from. The write-back sets bit 5, and also bit 6 for a write. res_pte is the updated value.
- R7: A page entry that needs no update causes no memory write. res_pte equals the fetched entry.
- R8: With mmu_en low at acceptance, no memory request is made. res_paddr is the zero-extended virtual address, res_bypass is 1, and res_fault and res_level are 0.
- R9: done is high for exactly one cycle. For a translated walk it comes in the cycle after the last read response, or in the cycle after the write-back is accepted.
- R10: After reset, req_ready is 1 and done and mem_req_valid are 0. req_ready is low from acceptance until done, so only one walk is in flight. A memory request keeps its address and kind until accepted.
- R11: res_write, res_fetch and res_super return the flags of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_super | input | 1 | Access is privileged |
| ctx_ptr | input | 32 | Context table pointer |
| ctx_num | input | CTX_W | Context number |
| mmu_en | input | 1 | Translation enable |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | 36 | Memory word address |
| mem_req_wdata | output | 32 | Write-back data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | Result valid pulse |
| res_pte | output | 32 | Final entry |
| res_level | output | 2 | Level where walk stopped |
| res_paddr | output | 36 | Physical address |
| res_fault | output | 10 | Fault code, 0 when none |
| res_bypass | output | 1 | Pass-through result, full permissions |
| res_write | output | 1 | Echoed store flag |
| res_fetch | output | 1 | Echoed fetch flag |
| res_super | output | 1 | Echoed privilege flag |

## Verification
The assertions assume the memory returns exactly one response for each accepted read, and only while that read is outstanding. They also assume it never responds to a write. The bench's memory model enforces this: it schedules a response only after it sees a read handshake, delays it by zero to two cycles, and holds it for one cycle. Ready is asserted at random so that requests are held under back-pressure. Requests are raised only while req_ready is high and dropped right after acceptance.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W  = 32;
    localparam int PTE_W = 32;
    localparam int PA_W  = 36;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ISSUE,
        S_RD_WAIT,
        S_WB_ISSUE,
        S_FINISH
    } walk_state_e;

    localparam logic [1:0] ET_INVALID = 2'd0;
    localparam logic [1:0] ET_TABLE   = 2'd1;
    localparam logic [1:0] ET_PAGE    = 2'd2;

    localparam logic [2:0] FT_INVALID = 3'd1;
    localparam logic [2:0] FT_XLATE   = 3'd4;

    localparam int REF_BIT = 5;
    localparam int MOD_BIT = 6;
endpackage

// File: rtl/ptw_next_addr.sv
// Address of the next table word: context slot for level 0, otherwise
// table base from the descriptor plus the scaled virtual index.
module ptw_next_addr
    import ptw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic [1:0]       lvl,
    input  logic [31:0]      ctx_ptr,
    input  logic [CTX_W-1:0] ctx_num,
    input  logic [31:2]      desc_ptr,
    input  logic [31:12]     va_hi,
    output logic [PA_W-1:0]  addr
);
    logic [PA_W-1:0] tbl_base;
    logic [PA_W-1:0] ctx_base;

    assign tbl_base = {desc_ptr, 6'b0};
    assign ctx_base = {ctx_ptr, 4'b0};

    always_comb begin
        unique case (lvl)
            2'd0:    addr = ctx_base + PA_W'({ctx_num, 2'b00});
            2'd1:    addr = tbl_base + PA_W'({va_hi[31:24], 2'b00});
            2'd2:    addr = tbl_base + PA_W'({va_hi[23:18], 2'b00});
            default: addr = tbl_base + PA_W'({va_hi[17:12], 2'b00});
        endcase
    end
endmodule

// File: rtl/ptw_leaf_calc.sv
// Physical address and status-bit update for a page entry at a given level.
module ptw_leaf_calc
    import ptw_pkg::*;
(
    input  logic [1:0]       lvl,
    input  logic [PTE_W-1:0] entry,
    input  logic [23:0]      va_lo,
    input  logic             is_write,
    output logic [PA_W-1:0]  paddr,
    output logic             wb_need,
    output logic [PTE_W-1:0] wb_entry
);
    logic [PA_W-1:0]  offset;
    logic [PTE_W-1:0] set_mask;

    always_comb begin
        unique case (lvl)
            2'd1:    offset = PA_W'(va_lo[23:0]);
            2'd2:    offset = PA_W'(va_lo[17:0]);
            default: offset = PA_W'(va_lo[11:0]);
        endcase
    end

    assign paddr = {entry[31:8], 12'b0} + offset;

    always_comb begin
        set_mask = '0;
        set_mask[REF_BIT] = 1'b1;
        set_mask[MOD_BIT] = is_write;
    end

    assign wb_need  = !entry[REF_BIT] || (is_write && !entry[MOD_BIT]);
    assign wb_entry = entry | set_mask;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_vaddr,
    input  logic             req_write,
    input  logic             req_fetch,
    input  logic             req_super,
    input  logic [31:0]      ctx_ptr,
    input  logic [CTX_W-1:0] ctx_num,
    input  logic             mmu_en,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_write,
    output logic [35:0]      mem_req_addr,
    output logic [31:0]      mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [31:0]      mem_rsp_data,
    output logic             done,
    output logic [31:0]      res_pte,
    output logic [1:0]       res_level,
    output logic [35:0]      res_paddr,
    output logic [9:0]       res_fault,
    output logic             res_bypass,
    output logic             res_write,
    output logic             res_fetch,
    output logic             res_super
);
    walk_state_e state_q, state_d;

    logic [1:0]       lvl_q;
    logic [PA_W-1:0]  addr_q;
    logic [VA_W-1:0]  va_q;
    logic             wr_q, fetch_q, super_q, bypass_q;
    logic [PTE_W-1:0] pte_q;
    logic [PA_W-1:0]  paddr_q;
    logic [9:0]       fault_q;

    logic [1:0]       na_lvl;
    logic [PA_W-1:0]  na_addr;
    logic [PA_W-1:0]  leaf_pa;
    logic             leaf_wb;
    logic [PTE_W-1:0] leaf_entry;
    logic [1:0]       etype;
    logic             descend, leaf_ok;
    logic [2:0]       ftype;

    assign etype   = mem_rsp_data[1:0];
    assign descend = (etype == ET_TABLE) && (lvl_q != 2'd3);
    assign leaf_ok = (etype == ET_PAGE) && (lvl_q != 2'd0);
    assign ftype   = (etype == ET_INVALID) ? FT_INVALID : FT_XLATE;
    assign na_lvl  = (state_q == S_IDLE) ? 2'd0 : lvl_q + 2'd1;

    ptw_next_addr #(.CTX_W(CTX_W)) u_next_addr (
        .lvl      (na_lvl),
        .ctx_ptr  (ctx_ptr),
        .ctx_num  (ctx_num),
        .desc_ptr (mem_rsp_data[31:2]),
        .va_hi    (va_q[31:12]),
        .addr     (na_addr)
    );

    ptw_leaf_calc u_leaf_calc (
        .lvl      (lvl_q),
        .entry    (mem_rsp_data),
        .va_lo    (va_q[23:0]),
        .is_write (wr_q),
        .paddr    (leaf_pa),
        .wb_need  (leaf_wb),
        .wb_entry (leaf_entry)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid) state_d = mmu_en ? S_RD_ISSUE : S_FINISH;
            S_RD_ISSUE: if (mem_req_ready) state_d = S_RD_WAIT;
            S_RD_WAIT: begin
                if (mem_rsp_valid) begin
                    if (descend)      state_d = S_RD_ISSUE;
                    else if (leaf_ok) state_d = leaf_wb ? S_WB_ISSUE : S_FINISH;
                    else              state_d = S_FINISH;
                end
            end
            S_WB_ISSUE: if (mem_req_ready) state_d = S_FINISH;
            S_FINISH:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q    <= '0;
            addr_q   <= '0;
            va_q     <= '0;
            wr_q     <= 1'b0;
            fetch_q  <= 1'b0;
            super_q  <= 1'b0;
            bypass_q <= 1'b0;
            pte_q    <= '0;
            paddr_q  <= '0;
            fault_q  <= '0;
        end else if (state_q == S_IDLE && req_valid) begin
            lvl_q    <= 2'd0;
            addr_q   <= na_addr;
            va_q     <= req_vaddr;
            wr_q     <= req_write;
            fetch_q  <= req_fetch;
            super_q  <= req_super;
            bypass_q <= !mmu_en;
            pte_q    <= '0;
            paddr_q  <= mmu_en ? '0 : PA_W'(req_vaddr);
            fault_q  <= '0;
        end else if (state_q == S_RD_WAIT && mem_rsp_valid) begin
            pte_q <= mem_rsp_data;
            if (descend) begin
                lvl_q  <= lvl_q + 2'd1;
                addr_q <= na_addr;
            end else if (leaf_ok) begin
                pte_q   <= leaf_entry;
                paddr_q <= leaf_pa;
            end else begin
                fault_q <= {lvl_q, 3'b000, ftype, 2'b00};
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == S_IDLE);
        mem_req_valid = (state_q == S_RD_ISSUE) || (state_q == S_WB_ISSUE);
        mem_req_write = (state_q == S_WB_ISSUE);
        mem_req_addr  = addr_q;
        mem_req_wdata = pte_q;
        done          = (state_q == S_FINISH);
        res_pte       = pte_q;
        res_level     = lvl_q;
        res_paddr     = paddr_q;
        res_fault     = fault_q;
        res_bypass    = bypass_q;
        res_write     = wr_q;
        res_fetch     = fetch_q;
        res_super     = super_q;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_write,
    input logic [35:0] mem_req_addr,
    input logic [31:0] mem_req_wdata,
    input logic        mem_rsp_valid,
    input logic        done,
    input logic [9:0]  res_fault,
    input logic [35:0] res_paddr,
    input logic [1:0]  res_level,
    input logic        res_bypass
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))); // R10

    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid); // R10

    AST_FAULT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault != 10'd0) |->
        ((res_fault[4:2] == 3'd1 || res_fault[4:2] == 3'd4) &&
         res_fault[7:5] == 3'd0 && res_fault[1:0] == 2'd0 && res_paddr == 36'd0)); // R4

    AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_bypass) |->
        (res_fault == 10'd0 && res_level == 2'd0 && res_paddr[35:32] == 4'd0)); // R8

    AST_WB_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> mem_req_wdata[5]); // R6

    AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid && mem_req_write) |-> $past(mem_rsp_valid)); // R6
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .res_fault     (res_fault),
    .res_paddr     (res_paddr),
    .res_level     (res_level),
    .res_bypass    (res_bypass)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0, req_fetch = 1'b0, req_super = 1'b0;
    logic [31:0] ctx_ptr = 32'h0010_0000;
    logic [7:0]  ctx_num = '0;
    logic        mmu_en = 1'b1;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready = 1'b0;
    logic [35:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [31:0] res_pte;
    logic [1:0]  res_level;
    logic [35:0] res_paddr;
    logic [9:0]  res_fault;
    logic        res_bypass, res_write, res_fetch, res_super;

    always #2.5 clk = ~clk;

    ptw_walker #(.CTX_W(8)) uut (.*);

    int checks = 0;
    int fails  = 0;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] mem [logic [35:0]];
    bit          fire_pend = 0, fire_we = 0, rd_busy = 0;
    logic [35:0] fire_addr, rd_addr, wb_addr_seen, first_rd_addr;
    logic [31:0] fire_wdata, wb_data_seen;
    int rd_delay = 0, neg_cnt = 0, last_rsp_neg = 0, last_wr_neg = 0;
    int rd_cnt = 0, wr_cnt = 0;

    function automatic logic [31:0] mrd(logic [35:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    initial forever begin
        @(negedge clk);
        neg_cnt++;
        mem_rsp_valid = 1'b0;
        if (fire_pend) begin
            fire_pend = 0;
            if (fire_we) begin
                mem[fire_addr] = fire_wdata;
                wr_cnt++;
                wb_addr_seen = fire_addr;
                wb_data_seen = fire_wdata;
                last_wr_neg = neg_cnt;
            end else begin
                if (rd_cnt == 0) first_rd_addr = fire_addr;
                rd_cnt++;
                rd_busy  = 1;
                rd_addr  = fire_addr;
                rd_delay = $urandom % 3;
            end
        end
        if (rd_busy) begin
            if (rd_delay == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mrd(rd_addr);
                rd_busy       = 0;
                last_rsp_neg  = neg_cnt;
            end else rd_delay--;
        end
        mem_req_ready = ($urandom % 4) != 0;
        if (mem_req_valid === 1'b1 && mem_req_ready) begin
            fire_pend  = 1;
            fire_we    = mem_req_write;
            fire_addr  = mem_req_addr;
            fire_wdata = mem_req_wdata;
        end
    end

    // ---------------- reference model ----------------
    logic [9:0]  e_fault;
    logic [1:0]  e_lvl;
    logic [31:0] e_pte;
    logic [35:0] e_pa, e_wba, e_first;
    int          e_nrd;
    bit          e_wb;

    function automatic logic [35:0] idx_off(int l, logic [31:0] va);
        case (l)
            1:       return 36'({va[31:24], 2'b00});
            2:       return 36'({va[23:18], 2'b00});
            default: return 36'({va[17:12], 2'b00});
        endcase
    endfunction

    task automatic ref_walk(logic [31:0] va, bit wr, bit en);
        logic [35:0] a;
        logic [31:0] e;
        logic [35:0] off;
        int l;
        e_fault = 0; e_lvl = 0; e_pte = 0; e_pa = 0; e_nrd = 0; e_wb = 0; e_wba = 0;
        e_first = {ctx_ptr, 4'b0} + 36'({ctx_num, 2'b00});
        if (!en) begin
            e_pa = {4'b0, va};
            return;
        end
        a = e_first;
        l = 0;
        forever begin
            e = mrd(a);
            e_nrd++;
            e_lvl = 2'(l);
            if (e[1:0] == 2'd0) begin
                e_fault = 10'({l[1:0], 8'h04}); e_pte = e; return;
            end else if (e[1:0] == 2'd3 || (e[1:0] == 2'd2 && l == 0) ||
                         (e[1:0] == 2'd1 && l == 3)) begin
                e_fault = 10'({l[1:0], 8'h10}); e_pte = e; return;
            end else if (e[1:0] == 2'd1) begin
                l++;
                a = {e[31:2], 6'b0} + idx_off(l, va);
            end else begin
                off = (l == 1) ? 36'(va[23:0]) : (l == 2) ? 36'(va[17:0]) : 36'(va[11:0]);
                e_pa = {e[31:8], 12'b0} + off;
                e_wb = !e[5] || (wr && !e[6]);
                e_pte = e | 32'h20 | (wr ? 32'h40 : 32'h0);
                e_wba = a;
                return;
            end
        end
    endtask

    // ---------------- one walk ----------------
    task automatic walk(logic [31:0] va, bit wr, bit fe, bit su, bit en, logic [7:0] cn);
        int guard;
        int done_neg;
        bit first;
        string t;
        ctx_num = cn;
        ref_walk(va, wr, en);
        @(negedge clk); #1;
        rd_cnt = 0; wr_cnt = 0;
        req_valid = 1; req_vaddr = va; req_write = wr; req_fetch = fe; req_super = su; mmu_en = en;
        @(posedge clk); #1;
        req_valid = 0;
        guard = 0; first = 1; done_neg = 0;
        forever begin
            @(negedge clk); #1;
            if (first) begin
                chk("R10", "busy after accept", req_ready, 0);
                first = 0;
            end
            if (done) begin done_neg = neg_cnt; break; end
            guard++;
            if (guard > 200) begin chk("R9", "done timeout", 0, 1); return; end
        end
        t = !en ? "R8" : (e_fault == 0) ? "R3" : (e_fault[4:2] == 3'd1) ? "R4" : "R5";
        chk(t, "fault", res_fault, e_fault);
        chk(t, "level", res_level, e_lvl);
        chk(t, "paddr", res_paddr, e_pa);
        chk(e_wb ? "R6" : "R2", "pte", res_pte, e_pte);
        chk(en ? "R2" : "R8", "read count", rd_cnt, e_nrd);
        chk(e_wb ? "R6" : "R7", "write count", wr_cnt, e_wb);
        chk("R8", "bypass flag", res_bypass, !en);
        chk("R11", "flags", {res_write, res_fetch, res_super}, {wr, fe, su});
        if (en) begin
            chk("R1", "first read addr", first_rd_addr, e_first);
            chk("R9", "done timing", done_neg, e_wb ? last_wr_neg : last_rsp_neg + 1);
        end
        if (e_wb) begin
            chk("R6", "wb addr", wb_addr_seen, e_wba);
            chk("R6", "wb data", wb_data_seen, e_pte);
        end
        @(negedge clk); #1;
        chk("R9", "done single cycle", done, 0);
    endtask

    // ---------------- table building ----------------
    localparam logic [35:0] CTX_T = 36'h0100_0000;
    localparam logic [35:0] T1 = 36'h0200_0000;
    localparam logic [35:0] T2 = 36'h0300_0000;
    localparam logic [35:0] T3 = 36'h0400_0000;

    function automatic logic [31:0] rnd_entry(logic [31:0] desc);
        int r = $urandom % 8;
        logic [31:0] v = $urandom;
        if (r == 0) return 32'h0;
        if (r == 1) return {v[31:2], 2'b11};
        if (r < 4)  return desc;
        return {v[31:2], 2'b10};
    endfunction

    function automatic logic [31:0] mkva(int i1, int i2, int i3, int off);
        return {8'(i1), 6'(i2), 6'(i3), 12'(off)};
    endfunction

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20240611);
        mem[CTX_T + 0]  = 32'h0020_0001;
        mem[CTX_T + 4]  = 32'h0;
        mem[CTX_T + 8]  = 32'h1234_5602;
        mem[CTX_T + 12] = 32'h0000_0003;
        for (int i = 0; i < 256; i++) mem[T1 + 36'(i * 4)] = rnd_entry(32'h0030_0001);
        for (int i = 0; i < 64; i++)  mem[T2 + 36'(i * 4)] = rnd_entry(32'h0040_0001);
        for (int i = 0; i < 64; i++)  mem[T3 + 36'(i * 4)] = rnd_entry(32'h0050_0001);
        mem[T1 + 36'h40] = 32'h0AB0_0022;
        mem[T1 + 36'h44] = 32'h0030_0001;
        mem[T1 + 36'h48] = 32'h0000_0003;
        mem[T2 + 36'd20] = 32'h0CD0_0002;
        mem[T2 + 36'd24] = 32'h0040_0001;
        mem[T2 + 36'd28] = 32'h0;
        mem[T3 + 36'd28] = 32'h0EF1_2362;
        mem[T3 + 36'd32] = 32'h0040_0001;
        mem[T3 + 36'd36] = 32'h0;
        mem[T3 + 36'd40] = 32'h0000_0007;

        repeat (3) @(negedge clk);
        #1;
        chk("R10", "reset ready", req_ready, 1);
        chk("R10", "reset done", done, 0);
        chk("R10", "reset mem valid", mem_req_valid, 0);
        rst_n = 1;

        walk(32'hDEAD_BEEF, 1, 0, 1, 0, 8'd0);             // R8 pass-through
        walk(32'h1000_0000, 0, 0, 0, 1, 8'd1);             // R4 context invalid
        walk(32'h1000_0000, 0, 1, 0, 1, 8'd2);             // R5 page in context
        walk(32'h1000_0000, 0, 0, 1, 1, 8'd3);             // R5 reserved context
        walk(mkva(16, 4, 8, 12'h456), 0, 0, 0, 1, 8'd0);   // R7 16 MB, no update
        walk(mkva(16, 4, 8, 12'h456), 1, 0, 0, 1, 8'd0);   // R6 set modified
        walk(mkva(16, 4, 8, 12'h456), 1, 0, 0, 1, 8'd0);   // R7 already dirty
        walk(mkva(17, 5, 3, 12'h0AB), 0, 1, 0, 1, 8'd0);   // R6 256 KB, set referenced
        walk(mkva(17, 6, 7, 12'hFFF), 1, 0, 1, 1, 8'd0);   // R3 4 KB page
        walk(mkva(17, 6, 8, 12'h000), 0, 0, 0, 1, 8'd0);   // R5 table at level 3
        walk(mkva(17, 6, 9, 12'h000), 0, 0, 0, 1, 8'd0);   // R4 invalid level 3
        walk(mkva(17, 6, 10, 12'h000), 0, 0, 0, 1, 8'd0);  // R5 reserved level 3
        walk(mkva(17, 7, 0, 12'h000), 0, 0, 0, 1, 8'd0);   // R4 invalid level 2
        walk(mkva(18, 0, 0, 12'h000), 0, 0, 0, 1, 8'd0);   // R5 reserved level 1

        for (int n = 0; n < 400; n++) begin
            logic [7:0] cn;
            cn = (($urandom % 8) == 0) ? 8'($urandom % 4) : 8'd0;
            walk($urandom, 1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 10) != 0, cn);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog expired: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule